// File: doc/BRIEF.md
# Clock-Divide Power Mode Controller

This block decides how fast the bus masters of a small microcontroller run and which low-power state the chip is in. Software writes a speed code; a nonzero code slows the CPU and the DMA engine to a power-of-two fraction of the system clock. Every other on-chip peripheral keeps running at the undivided rate. A speed change never lands in the middle of a bus transfer. It waits for the strobe that marks the end of the current bus cycle.

The controller also steps the chip between its run states (full speed, divided speed), light sleep, software standby, hardware standby and reset. The slow rate is delivered as a single-cycle clock-enable pulse on `cpu_ce`, which a downstream gating cell uses. A wait-state hint tells the bus how many undivided clock states the current access lasts. A small module-stop register holds one stop request per gated peripheral.

Top module: `pwrmode_ctrl`

## Requirements
- R1: A speed code of 0 selects full speed, where `mode_o` = 1 and the divisor is 1. Codes 1 to 5 select divided speed (`mode_o` = 2) with divisors 2, 4, 8, 16 and 32. Codes 6 and 7 also select divide-by-32. Mode encoding: 0 reset, 1 full, 2 divided, 3 sleep, 4 software standby, 5 hardware standby.
- R2: A written speed code takes effect only on a clock edge where `bus_end` is high. Until then, `mode_o`, `cpu_ce` and `wait_hint` keep the old rate.
- R3: At full speed `cpu_ce` is high on every cycle. At divided speed by N it is high for one cycle in every N. When a new divisor takes effect, the first pulse comes N cycles after the switching edge. `periph_ce` stays high in full, divided and sleep modes.
- R4: `wait_hint` equals the active divisor for a memory access (`acc_io` = 0) and twice the divisor for an I/O register access (`acc_io` = 1).
- R5: A `sleep_stb` with standby-enable (control bit 0) and low-speed (control bit 1) both clear enters sleep. Either `irq` or `ext_irq` leaves sleep and returns to the divisor that was active before.
- R6: A `sleep_stb` with standby-enable set and both low-speed and watchdog-select (control bit 2) clear enters software standby. Only `ext_irq` leaves it, back to the retained divisor. Any other control combination makes `sleep_stb` have no effect.
- R7: `res_n` low, `mres_n` low, or `wdt_ovf` high forces `mode_o` = 0 and clears the speed code, control and module-stop registers. One cycle after the request ends, the block is at full speed.
- R8: `stby_n` low forces hardware standby (`mode_o` = 5) from any state, overriding reset requests and interrupts. On release the block passes through one reset cycle and then runs at full speed with all registers cleared.
- R9: The module-stop register (address 2) drives `mstop_o`. Bit 1 stops the real-time clock and bit 0 stops the USB function. A 1 stops the module and a 0 releases it. Bits 7 to 2 ignore writes and read as 0.
- R10: Register writes (address 0 speed code in bits 2:0, address 1 control, address 2 module stop) are accepted only in full or divided mode. In any other mode they are ignored.
- R11: `cpu_ce` is low in sleep, both standby modes and reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided system clock |
| res_n | input | 1 | External reset pin, active low |
| mres_n | input | 1 | Manual reset pin, active low |
| wdt_ovf | input | 1 | Watchdog overflow, forces reset |
| stby_n | input | 1 | Hardware standby pin, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| bus_end | input | 1 | Current bus cycle ends on this edge |
| sleep_stb | input | 1 | Sleep instruction executed |
| irq | input | 1 | Internal interrupt request |
| ext_irq | input | 1 | External interrupt request |
| acc_io | input | 1 | Current access targets an I/O register |
| mode_o | output | 3 | Current power mode |
| cpu_ce | output | 1 | Clock enable for CPU and DMA |
| periph_ce | output | 1 | Clock enable for peripherals |
| wait_hint | output | 7 | Access length in undivided states |
| mstop_o | output | 2 | Module stop requests (1 RTC, 0 USB) |

## Verification
Several rules are checked by the assertions on every cycle. The active divisor never moves without a bus-cycle-end strobe. Software standby is left only through an external interrupt, and an interrupt in sleep always lands in a run mode. The standby pin wins over everything. Writes made outside the run modes leave the speed code alone, and divided-speed enables never come back to back. Only the bench scenarios show the exact pulse spacing and the full-length first period after a switch. The same holds for the decoding of every speed code into a wait hint and for the control combinations that make a sleep strobe do nothing. Register clearing after a watchdog, manual reset or standby release is likewise seen only through read-back.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

   typedef enum logic [2:0] {
      PM_RESET  = 3'd0,
      PM_HIGH   = 3'd1,
      PM_MED    = 3'd2,
      PM_SLEEP  = 3'd3,
      PM_SWSTBY = 3'd4,
      PM_HWSTBY = 3'd5
   } pm_mode_e;

   localparam int unsigned REG_SPEED = 0;
   localparam int unsigned REG_CTRL  = 1;
   localparam int unsigned REG_MSTOP = 2;

   // control register bit positions
   localparam int unsigned CTL_SBY = 0;
   localparam int unsigned CTL_LS  = 1;
   localparam int unsigned CTL_WD  = 2;
   localparam int unsigned CTL_W   = 3;

   // speed code to log2(divisor); codes beyond the last step saturate
   function automatic int unsigned code_to_shift(input int unsigned code,
                                                 input int unsigned max_sh);
      if (code == 0)
         return 0;
      else if (code > max_sh)
         return max_sh;
      else
         return code;
   endfunction

endpackage

// File: rtl/pwrmode_regs.sv
module pwrmode_regs
   import pwrmode_pkg::*;
#(
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned MS_N   = 2,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [SEL_W-1:0]  spd_sel,
   output logic              sby_en,
   output logic              lowspd,
   output logic              wdsel,
   output logic [MS_N-1:0]   mstop
);

   localparam logic [ADDR_W-1:0] A_SPD = ADDR_W'(REG_SPEED);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_MS  = ADDR_W'(REG_MSTOP);

   logic [SEL_W-1:0] spd_q;
   logic [CTL_W-1:0] ctl_q;
   logic [MS_N-1:0]  ms_q;

   always_ff @(posedge clk) begin
      if (clr) begin
         spd_q <= '0;
         ctl_q <= '0;
      end else if (wr_en) begin
         if (addr == A_SPD) spd_q <= wdata[SEL_W-1:0];
         if (addr == A_CTL) ctl_q <= wdata[CTL_W-1:0];
      end
   end

   // one flop per stoppable module; reserved positions have no storage
   for (genvar b = 0; b < MS_N; b++) begin : g_mstop
      always_ff @(posedge clk) begin
         if (clr)
            ms_q[b] <= 1'b0;
         else if (wr_en && addr == A_MS)
            ms_q[b] <= wdata[b];
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_SPD:   rdata[SEL_W-1:0] = spd_q;
         A_CTL:   rdata[CTL_W-1:0] = ctl_q;
         A_MS:    rdata[MS_N-1:0]  = ms_q;
         default: rdata = '0;
      endcase
   end

   assign spd_sel = spd_q;
   assign sby_en  = ctl_q[CTL_SBY];
   assign lowspd  = ctl_q[CTL_LS];
   assign wdsel   = ctl_q[CTL_WD];
   assign mstop   = ms_q;

   assert_mstop_hold_R9: assert property (@(posedge clk) disable iff (clr)
      !(wr_en && addr == A_MS) |=> $stable(ms_q))
      else $error("module-stop bits moved without a write");

endmodule

// File: rtl/pwrmode_fsm.sv
module pwrmode_fsm
   import pwrmode_pkg::*;
#(
   parameter int unsigned SH_W = 3
) (
   input  logic            clk,
   input  logic            rst_req,
   input  logic            stby_n,
   input  logic            bus_end,
   input  logic            sleep_stb,
   input  logic            irq,
   input  logic            ext_irq,
   input  logic [SH_W-1:0] req_sh,
   input  logic            sby_en,
   input  logic            lowspd,
   input  logic            wdsel,
   output pm_mode_e        mode,
   output logic [SH_W-1:0] act_sh,
   output logic            restart
);

   pm_mode_e        mode_q, mode_d;
   logic [SH_W-1:0] sh_q, sh_d;
   logic            go_sleep, go_swstby;
   pm_mode_e        run_mode;

   assign go_sleep  = sleep_stb && !lowspd && !sby_en;
   assign go_swstby = sleep_stb && !lowspd && sby_en && !wdsel;
   assign run_mode  = (sh_q == '0) ? PM_HIGH : PM_MED;

   always_comb begin
      mode_d  = mode_q;
      sh_d    = sh_q;
      restart = 1'b0;
      if (!stby_n) begin
         mode_d = PM_HWSTBY;
         sh_d   = '0;
      end else if (mode_q == PM_HWSTBY || rst_req) begin
         mode_d = PM_RESET;
         sh_d   = '0;
      end else begin
         unique case (mode_q)
            PM_RESET: begin
               mode_d  = PM_HIGH;
               restart = 1'b1;
            end
            PM_HIGH, PM_MED: begin
               if (bus_end) begin
                  sh_d    = req_sh;
                  restart = (req_sh != sh_q);
                  mode_d  = (req_sh == '0) ? PM_HIGH : PM_MED;
               end
               if (go_sleep)
                  mode_d = PM_SLEEP;
               else if (go_swstby)
                  mode_d = PM_SWSTBY;
            end
            PM_SLEEP: begin
               if (irq || ext_irq) begin
                  mode_d  = run_mode;
                  restart = 1'b1;
               end
            end
            PM_SWSTBY: begin
               if (ext_irq) begin
                  mode_d  = run_mode;
                  restart = 1'b1;
               end
            end
            default: begin
               mode_d = PM_RESET;
               sh_d   = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      mode_q <= mode_d;
      sh_q   <= sh_d;
   end

   assign mode   = mode_q;
   assign act_sh = sh_q;

   assert_div_at_bus_end_R2: assert property (@(posedge clk)
      disable iff (rst_req || !stby_n)
      !bus_end |=> $stable(sh_q))
      else $error("divisor changed outside a bus-cycle end");

   assert_sleep_wake_R5: assert property (@(posedge clk)
      disable iff (rst_req || !stby_n)
      (mode_q == PM_SLEEP && (irq || ext_irq)) |=>
         (mode_q == PM_HIGH || mode_q == PM_MED))
      else $error("interrupt did not wake from sleep");

   assert_swstby_hold_R6: assert property (@(posedge clk)
      disable iff (rst_req || !stby_n)
      (mode_q == PM_SWSTBY && !ext_irq) |=> mode_q == PM_SWSTBY)
      else $error("software standby left without external interrupt");

   assert_hw_standby_R8: assert property (@(posedge clk)
      disable iff (rst_req && stby_n)
      !stby_n |=> mode_q == PM_HWSTBY)
      else $error("standby pin not obeyed");

endmodule

// File: rtl/pwrmode_clkdiv.sv
module pwrmode_clkdiv
   import pwrmode_pkg::*;
#(
   parameter int unsigned MAX_SH = 5,
   parameter int unsigned SH_W   = 3,
   parameter int unsigned WAIT_W = MAX_SH + 2
) (
   input  logic              clk,
   input  logic              hold,
   input  pm_mode_e          mode,
   input  logic [SH_W-1:0]   act_sh,
   input  logic              restart,
   input  logic              acc_io,
   output logic              cpu_ce,
   output logic              periph_ce,
   output logic [WAIT_W-1:0] wait_hint
);

   localparam int unsigned CNT_W = (MAX_SH < 1) ? 1 : MAX_SH;

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  lim;
   logic [WAIT_W-1:0] div_val;

   assign div_val = WAIT_W'(1) << act_sh;
   assign lim     = CNT_W'(div_val - WAIT_W'(1));

   always_ff @(posedge clk) begin
      if (hold || restart || mode != PM_MED)
         cnt_q <= '0;
      else if (cnt_q == lim)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cpu_ce    = (mode == PM_HIGH) || (mode == PM_MED && cnt_q == lim);
   assign periph_ce = (mode == PM_HIGH) || (mode == PM_MED) || (mode == PM_SLEEP);
   assign wait_hint = acc_io ? (div_val << 1) : div_val;

   assert_ce_spacing_R3: assert property (@(posedge clk) disable iff (hold)
      (mode == PM_MED && cpu_ce) |=> !(mode == PM_MED && cpu_ce))
      else $error("divided enable pulses back to back");

endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
   import pwrmode_pkg::*;
#(
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned MAX_SH = 5,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned MS_N   = 2,
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned SH_W   = $clog2(MAX_SH + 1),
   parameter int unsigned WAIT_W = MAX_SH + 2
) (
   input  logic              clk,
   input  logic              res_n,
   input  logic              mres_n,
   input  logic              wdt_ovf,
   input  logic              stby_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              bus_end,
   input  logic              sleep_stb,
   input  logic              irq,
   input  logic              ext_irq,
   input  logic              acc_io,
   output logic [2:0]        mode_o,
   output logic              cpu_ce,
   output logic              periph_ce,
   output logic [WAIT_W-1:0] wait_hint,
   output logic [MS_N-1:0]   mstop_o
);

   if (SEL_W < 1 || MAX_SH < 1) begin : g_bad_width
      $error("speed field and divider range must be nonzero");
   end
   if (MAX_SH > (1 << SEL_W) - 1) begin : g_bad_range
      $error("speed field too narrow to reach the largest divisor");
   end
   if (DATA_W < SEL_W || DATA_W < MS_N || DATA_W < CTL_W) begin : g_bad_data
      $error("register data bus narrower than a register");
   end
   if (WAIT_W < MAX_SH + 2) begin : g_bad_wait
      $error("wait hint cannot hold twice the largest divisor");
   end

   logic            rst_req, clr, wr_ok;
   logic [SEL_W-1:0] spd_sel;
   logic            sby_en, lowspd, wdsel;
   logic [SH_W-1:0] req_sh, act_sh;
   logic            restart;
   pm_mode_e        mode;

   assign rst_req = !res_n || !mres_n || wdt_ovf;
   assign clr     = rst_req || !stby_n || mode == PM_HWSTBY;
   assign wr_ok   = reg_wr && (mode == PM_HIGH || mode == PM_MED);
   assign req_sh  = SH_W'(code_to_shift(int'(spd_sel), MAX_SH));

   pwrmode_regs #(
      .SEL_W (SEL_W),
      .DATA_W(DATA_W),
      .MS_N  (MS_N),
      .ADDR_W(ADDR_W)
   ) regs_i (
      .clk    (clk),
      .clr    (clr),
      .wr_en  (wr_ok),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .spd_sel(spd_sel),
      .sby_en (sby_en),
      .lowspd (lowspd),
      .wdsel  (wdsel),
      .mstop  (mstop_o)
   );

   pwrmode_fsm #(
      .SH_W(SH_W)
   ) fsm_i (
      .clk      (clk),
      .rst_req  (rst_req),
      .stby_n   (stby_n),
      .bus_end  (bus_end),
      .sleep_stb(sleep_stb),
      .irq      (irq),
      .ext_irq  (ext_irq),
      .req_sh   (req_sh),
      .sby_en   (sby_en),
      .lowspd   (lowspd),
      .wdsel    (wdsel),
      .mode     (mode),
      .act_sh   (act_sh),
      .restart  (restart)
   );

   pwrmode_clkdiv #(
      .MAX_SH(MAX_SH),
      .SH_W  (SH_W),
      .WAIT_W(WAIT_W)
   ) div_i (
      .clk      (clk),
      .hold     (rst_req || !stby_n),
      .mode     (mode),
      .act_sh   (act_sh),
      .restart  (restart),
      .acc_io   (acc_io),
      .cpu_ce   (cpu_ce),
      .periph_ce(periph_ce),
      .wait_hint(wait_hint)
   );

   assign mode_o = mode;

   assert_wr_blocked_R10: assert property (@(posedge clk)
      disable iff (rst_req || !stby_n)
      (reg_wr && (mode == PM_SLEEP || mode == PM_SWSTBY)) |=> $stable(spd_sel))
      else $error("speed code written outside a run mode");

endmodule

// File: tb/pwrmode_ctrl_tb_top.sv
module pwrmode_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       res_n = 1'b0, mres_n = 1'b1, wdt_ovf = 1'b0, stby_n = 1'b1;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       bus_end = 1'b0, sleep_stb = 1'b0, irq = 1'b0, ext_irq = 1'b0;
   logic       acc_io = 1'b0;
   logic [2:0] mode_o;
   logic       cpu_ce, periph_ce;
   logic [6:0] wait_hint;
   logic [1:0] mstop_o;

   int nchk = 0;
   int nfail = 0;

   always #4 clk = ~clk;

   pwrmode_ctrl dut_i (
      .clk(clk), .res_n(res_n), .mres_n(mres_n), .wdt_ovf(wdt_ovf),
      .stby_n(stby_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_end(bus_end),
      .sleep_stb(sleep_stb), .irq(irq), .ext_irq(ext_irq), .acc_io(acc_io),
      .mode_o(mode_o), .cpu_ce(cpu_ce), .periph_ce(periph_ce),
      .wait_hint(wait_hint), .mstop_o(mstop_o)
   );

   // op codes for the vector walk
   localparam int OP_IDLE = 0, OP_WSPD = 1, OP_WCTL = 2, OP_BEND = 3,
                  OP_SLP = 4, OP_IRQ = 5, OP_EXT = 6, OP_WMS = 7;

   // {op, data, expected mode, expected memory wait hint}
   localparam int NV = 33;
   localparam logic [20:0] VEC [NV] = '{
      {3'd1, 8'd2, 3'd1, 7'd1},   // R2 write, not yet active
      {3'd0, 8'd0, 3'd1, 7'd1},   // R2 still full speed
      {3'd3, 8'd0, 3'd2, 7'd4},   // R1 divide by 4
      {3'd1, 8'd0, 3'd2, 7'd4},   // R2 back-to-full held off
      {3'd3, 8'd0, 3'd1, 7'd1},   // R1 full speed
      {3'd1, 8'd5, 3'd1, 7'd1},
      {3'd3, 8'd0, 3'd2, 7'd32},  // R1 code 5
      {3'd4, 8'd0, 3'd3, 7'd32},  // R5 sleep
      {3'd5, 8'd0, 3'd2, 7'd32},  // R5 wake keeps divisor
      {3'd2, 8'd1, 3'd2, 7'd32},
      {3'd4, 8'd0, 3'd4, 7'd32},  // R6 software standby
      {3'd5, 8'd0, 3'd4, 7'd32},  // R6 internal irq ignored
      {3'd0, 8'd0, 3'd4, 7'd32},
      {3'd6, 8'd0, 3'd2, 7'd32},  // R6 external wake
      {3'd1, 8'd7, 3'd2, 7'd32},
      {3'd3, 8'd0, 3'd2, 7'd32},  // R1 code 7 saturates
      {3'd1, 8'd1, 3'd2, 7'd32},
      {3'd3, 8'd0, 3'd2, 7'd2},   // R1 code 1
      {3'd2, 8'd3, 3'd2, 7'd2},
      {3'd4, 8'd0, 3'd2, 7'd2},   // R6 low-speed set: no effect
      {3'd2, 8'd5, 3'd2, 7'd2},
      {3'd4, 8'd0, 3'd2, 7'd2},   // R6 watchdog-select set: no effect
      {3'd2, 8'd2, 3'd2, 7'd2},
      {3'd4, 8'd0, 3'd2, 7'd2},   // R6 low-speed only: no effect
      {3'd2, 8'd0, 3'd2, 7'd2},
      {3'd4, 8'd0, 3'd3, 7'd2},   // R5 sleep
      {3'd6, 8'd0, 3'd2, 7'd2},   // R5 external irq also wakes
      {3'd1, 8'd3, 3'd2, 7'd2},
      {3'd3, 8'd0, 3'd2, 7'd8},   // R1 code 3
      {3'd1, 8'd4, 3'd2, 7'd8},
      {3'd3, 8'd0, 3'd2, 7'd16},  // R1 code 4
      {3'd1, 8'd6, 3'd2, 7'd16},
      {3'd3, 8'd0, 3'd2, 7'd32}   // R1 code 6 saturates
   };

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // drive one cycle of stimulus at a falling edge, return at the next one
   task automatic do_op(input int op, input int data);
      case (op)
         OP_WSPD: begin reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'(data); end
         OP_WCTL: begin reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'(data); end
         OP_WMS:  begin reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'(data); end
         OP_BEND: bus_end = 1'b1;
         OP_SLP:  sleep_stb = 1'b1;
         OP_IRQ:  irq = 1'b1;
         OP_EXT:  ext_irq = 1'b1;
         default: ;
      endcase
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'd0;
      bus_end = 1'b0; sleep_stb = 1'b0; irq = 1'b0; ext_irq = 1'b0;
   endtask

   task automatic rd(input int addr, input string tag, input int exp);
      reg_addr = 2'(addr);
      #1;
      chk(tag, int'(reg_rdata), exp);
      reg_addr = 2'd0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      // reset state, R7
      repeat (3) @(negedge clk);
      chk("R7 mode in reset", int'(mode_o), 0);
      chk("R11 cpu_ce in reset", int'(cpu_ce), 0);
      chk("R9 mstop after reset", int'(mstop_o), 0);
      res_n = 1'b1;
      @(negedge clk);
      chk("R7 full speed after reset", int'(mode_o), 1);
      chk("R3 cpu_ce at full speed", int'(cpu_ce), 1);
      chk("R4 wait hint at full speed", int'(wait_hint), 1);
      rd(0, "R7 speed code after reset", 0);

      // vector walk: R1 R2 R5 R6
      for (int i = 0; i < NV; i++) begin
         do_op(int'(VEC[i][20:18]), int'(VEC[i][17:10]));
         chk($sformatf("R1 R2 R5 R6 row %0d mode", i), int'(mode_o), int'(VEC[i][9:7]));
         chk($sformatf("R1 R4 row %0d wait", i), int'(wait_hint), int'(VEC[i][6:0]));
      end

      // R4 I/O access doubles the hint (divide by 32 active)
      acc_io = 1'b1;
      #1;
      chk("R4 io wait div32", int'(wait_hint), 64);
      acc_io = 1'b0;

      // R3 divide by 4 pulse spacing, first period full length
      do_op(OP_WSPD, 2);
      do_op(OP_BEND, 0);
      for (int k = 0; k < 8; k++) begin
         chk($sformatf("R3 div4 ce cycle %0d", k), int'(cpu_ce), (k % 4 == 3) ? 1 : 0);
         chk("R3 periph_ce divided", int'(periph_ce), 1);
         @(negedge clk);
      end
      acc_io = 1'b1;
      #1;
      chk("R4 io wait div4", int'(wait_hint), 8);
      acc_io = 1'b0;

      // R3 full speed every cycle
      do_op(OP_WSPD, 0);
      do_op(OP_BEND, 0);
      for (int k = 0; k < 3; k++) begin
         chk("R3 full-speed ce", int'(cpu_ce), 1);
         @(negedge clk);
      end

      // R9 module stop register
      do_op(OP_WMS, 8'hFF);
      chk("R9 mstop all set", int'(mstop_o), 3);
      rd(2, "R9 reserved bits read 0", 3);
      do_op(OP_WMS, 8'h02);
      chk("R9 RTC stopped USB running", int'(mstop_o), 2);
      do_op(OP_WCTL, 7);
      rd(1, "R10 control readback", 7);
      do_op(OP_WCTL, 0);

      // R10 R11 writes ignored in sleep, enable off
      do_op(OP_WSPD, 1);
      do_op(OP_BEND, 0);
      do_op(OP_SLP, 0);
      chk("R5 entered sleep", int'(mode_o), 3);
      for (int k = 0; k < 4; k++) begin
         chk("R11 cpu_ce in sleep", int'(cpu_ce), 0);
         chk("R3 periph_ce in sleep", int'(periph_ce), 1);
         @(negedge clk);
      end
      do_op(OP_WSPD, 0);
      do_op(OP_WMS, 0);
      do_op(OP_IRQ, 0);
      chk("R5 wake to divided", int'(mode_o), 2);
      rd(0, "R10 speed write in sleep ignored", 1);
      chk("R10 mstop write in sleep ignored", int'(mstop_o), 2);

      // R8 hardware standby, beats reset and interrupts
      stby_n = 1'b0;
      @(negedge clk);
      chk("R8 hw standby entered", int'(mode_o), 5);
      chk("R11 cpu_ce in hw standby", int'(cpu_ce), 0);
      chk("R8 periph_ce in hw standby", int'(periph_ce), 0);
      res_n = 1'b0;
      irq = 1'b1;
      ext_irq = 1'b1;
      @(negedge clk);
      chk("R8 standby over reset and irq", int'(mode_o), 5);
      res_n = 1'b1;
      irq = 1'b0;
      ext_irq = 1'b0;
      stby_n = 1'b1;
      @(negedge clk);
      chk("R8 reset cycle after release", int'(mode_o), 0);
      @(negedge clk);
      chk("R8 full speed after release", int'(mode_o), 1);
      rd(0, "R8 speed cleared", 0);
      chk("R8 mstop cleared", int'(mstop_o), 0);

      // R7 watchdog overflow cancels divided speed
      do_op(OP_WSPD, 3);
      do_op(OP_BEND, 0);
      chk("R7 divided before watchdog", int'(mode_o), 2);
      wdt_ovf = 1'b1;
      @(negedge clk);
      wdt_ovf = 1'b0;
      chk("R7 watchdog reset", int'(mode_o), 0);
      chk("R11 cpu_ce watchdog reset", int'(cpu_ce), 0);
      @(negedge clk);
      chk("R7 full speed after watchdog", int'(mode_o), 1);
      rd(0, "R7 speed cleared by watchdog", 0);

      // R7 manual reset pin
      do_op(OP_WSPD, 2);
      do_op(OP_BEND, 0);
      mres_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R7 manual reset", int'(mode_o), 0);
      mres_n = 1'b1;
      @(negedge clk);
      chk("R7 full speed after manual reset", int'(mode_o), 1);
      chk("R4 wait after manual reset", int'(wait_hint), 1);

      finish_run();
   end

endmodule